// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a 10-bit successive-approximation converter. Once a conversion starts, it latches the requested input channel and drives that channel to the analog multiplexer. It then holds a sample-and-hold strobe high for a fixed number of clocks. After that it tests one result bit per clock, most significant bit first. For each bit it drives a trial code to an external DAC. If the comparator reports that the DAC level is above the held input, that bit is cleared again.

A conversion can start in three ways. In single mode it starts on an explicit start pulse. In free-running mode the first conversion starts on a start pulse, and each later one begins on the clock after the previous one completes. In auto-trigger mode it starts on a rising edge of one selected trigger line. Each finished code is written to a result register in one step, and a sticky completion flag is raised at the same time. Software clears the flag by writing a one. The result is presented in a 16-bit readout, either right-aligned or left-aligned.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, busy, sample_hold, irq_flag, dac_code and result are all zero.
- R2: With an ideal comparator (cmp_gt high when dac_code is greater than the held input), the stored result equals the held input code for every code from 0 to 1023.
- R3: On the first trial cycle after sampling, dac_code is 0x200, which is only the most significant bit set. The bits are then resolved one per clock, from the top bit down to bit 0.
- R4: sample_hold is high for exactly SAMPLE_CYC clocks after a start and low during all bit trials. The analog input may change after sample_hold falls without changing the result.
- R5: In single mode (mode_sel = 0), no conversion starts unless start_req is high while the block is idle.
- R6: A start_req or trigger edge that arrives while busy is high is ignored. It neither restarts nor queues a conversion.
- R7: In free-running mode (mode_sel = 1), a new sampling phase begins on the clock after each completion, and busy stays high between the two conversions.
- R8: In auto-trigger mode (mode_sel = 2), a conversion starts on a rising edge of trig_in[trig_sel]. Edges on the other trigger lines, and a trigger level held high, start nothing.
- R9: irq_flag is set on the clock edge that writes the result. It stays set until irq_clr is sampled high, and setting takes priority over clearing.
- R10: When left_adj is 0, the result is in bits [9:0] and bits [15:10] are zero. When left_adj is 1, the result is in bits [15:6] and bits [5:0] are zero. The alignment is applied at readout, so toggling left_adj changes the readout at once.
- R11: While a conversion is in progress, result keeps the previous result and changes only at completion.
- R12: busy rises on the edge that accepts a start and falls on the edge that ends the final trial. From that accepting edge, irq_flag rises SAMPLE_CYC + 10 clocks later.
- R13: chan_mux takes the value of chan_in (one of 8 channels) when a conversion starts, and it holds that value for the whole conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Start mode: 0 single, 1 free-running, 2 auto-trigger (3 behaves as single) |
| start_req | input | 1 | Start request, sampled while idle |
| trig_in | input | 4 | Candidate trigger lines |
| trig_sel | input | 2 | Index of the trigger line used in auto-trigger mode |
| left_adj | input | 1 | Readout alignment: 1 places the result in bits [15:6] |
| irq_clr | input | 1 | Write-one-to-clear for the completion flag |
| chan_in | input | 3 | Requested input channel |
| cmp_gt | input | 1 | Comparator: DAC level is above the held input |
| chan_mux | output | 3 | Channel driven to the analog multiplexer |
| sample_hold | output | 1 | High while the input is being sampled |
| dac_code | output | 10 | Trial code driven to the DAC |
| busy | output | 1 | Conversion in progress |
| result | output | 16 | Aligned conversion result |
| irq_flag | output | 1 | Sticky conversion-complete flag |

## Verification
The bench aims at the all-zero and all-one codes and at the codes on either side of the midpoint. A sequencer that shifts its bit mask wrongly, or that resolves the last bit one cycle late, returns a wrong code at exactly these extremes. It also changes the analog input and the channel request right after sampling ends, which exposes a design that keeps tracking the input or re-reads the channel during the conversion. It sends start pulses and trigger edges while a conversion is running, and edges on unselected trigger lines. A design that queues or restarts on these shows a second completion or a stretched latency. Free-running hand-over, the priority of setting the flag over clearing it, and toggling the alignment on a stored result are also checked, because a gap, a lost flag or a stale readout shows up there.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_FREE   = 2'd1,
    MODE_AUTO   = 2'd2,
    MODE_RSVD   = 2'd3
  } conv_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_TRIAL  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sar_start_gen.sv
module sar_start_gen
  import sar_pkg::*;
#(
  parameter int NTRIG_LOG2 = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  conv_mode_e                 mode,
  input  logic                       start_req,
  input  logic [(1<<NTRIG_LOG2)-1:0] trig_in,
  input  logic [NTRIG_LOG2-1:0]      trig_sel,
  input  logic                       idle,
  output logic                       go
);
  logic trig_now;
  logic trig_prev;

  assign trig_now = trig_in[trig_sel];

  // previous level of the selected line, for rising-edge detection
  always_ff @(posedge clk) begin
    if (rst) trig_prev <= 1'b0;
    else     trig_prev <= trig_now;
  end

  always_comb begin
    if (mode == MODE_AUTO) go = idle && trig_now && !trig_prev;
    else                   go = idle && start_req;
  end
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine
  import sar_pkg::*;
#(
  parameter int NBITS      = 10,
  parameter int SAMPLE_CYC = 2,
  parameter int CHW        = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             free_run,
  input  logic [CHW-1:0]   chan_in,
  input  logic             cmp_gt,
  output logic             busy,
  output logic             sample_hold,
  output logic [NBITS-1:0] dac_code,
  output logic [CHW-1:0]   chan_mux,
  output logic             done,
  output logic [NBITS-1:0] code
);
  localparam int CW = $clog2(SAMPLE_CYC + 1);
  localparam logic [NBITS-1:0] MSB_ONE = {1'b1, {(NBITS-1){1'b0}}};

  seq_state_e       state;
  logic [CW-1:0]    cnt;
  logic [NBITS-1:0] mask;
  logic [NBITS-1:0] dac_q;
  logic [NBITS-1:0] kept;
  logic             busy_q, sh_q;
  logic [CHW-1:0]   chan_q;

  // the bit under trial survives unless the DAC overshoots the input
  assign kept = cmp_gt ? (dac_q & ~mask) : dac_q;
  assign done = (state == ST_TRIAL) && mask[0];
  assign code = kept;

  assign busy        = busy_q;
  assign sample_hold = sh_q;
  assign dac_code    = dac_q;
  assign chan_mux    = chan_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      mask   <= '0;
      dac_q  <= '0;
      busy_q <= 1'b0;
      sh_q   <= 1'b0;
      chan_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (go) begin
            state  <= ST_SAMPLE;
            cnt    <= '0;
            busy_q <= 1'b1;
            sh_q   <= 1'b1;
            chan_q <= chan_in;
          end
        end
        ST_SAMPLE: begin
          if (cnt == CW'(SAMPLE_CYC - 1)) begin
            state <= ST_TRIAL;
            sh_q  <= 1'b0;
            dac_q <= MSB_ONE;
            mask  <= MSB_ONE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TRIAL: begin
          if (mask[0]) begin
            dac_q <= '0;
            mask  <= '0;
            if (free_run) begin
              state  <= ST_SAMPLE;
              cnt    <= '0;
              sh_q   <= 1'b1;
              chan_q <= chan_in;
            end else begin
              state  <= ST_IDLE;
              busy_q <= 1'b0;
            end
          end else begin
            dac_q <= kept | (mask >> 1);
            mask  <= mask >> 1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R12: sampling only happens inside a busy window
  p_sh_busy_r12: assert property (@(posedge clk) disable iff (rst)
    sample_hold |-> busy);

  // R3: the first trial presents only the top bit
  p_first_trial_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(sample_hold) |-> dac_code == MSB_ONE);

  // R13: channel is frozen while a conversion runs
  p_chan_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> $stable(chan_mux));
endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
  parameter int NBITS = 10,
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [NBITS-1:0] code,
  input  logic             left_adj,
  input  logic             irq_clr,
  output logic [RES_W-1:0] result,
  output logic             irq
);
  localparam int PAD = RES_W - NBITS;

  logic [NBITS-1:0] raw_q;
  logic             irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr) raw_q <= code;
      if (wr)           irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  assign result = left_adj ? (RES_W'(raw_q) << PAD) : RES_W'(raw_q);
  assign irq    = irq_q;

  // R9: flag is sticky until cleared, and a write always sets it
  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);
  p_irq_set_r9: assert property (@(posedge clk) disable iff (rst)
    wr |=> irq);

  // R11: stored code moves only on a completion write
  p_raw_atomic_r11: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(raw_q));
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int NBITS      = 10,
  parameter int RES_W      = 16,
  parameter int SAMPLE_CYC = 2,
  parameter int CHW        = 3,
  parameter int NTRIG_LOG2 = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [1:0]                 mode_sel,
  input  logic                       start_req,
  input  logic [(1<<NTRIG_LOG2)-1:0] trig_in,
  input  logic [NTRIG_LOG2-1:0]      trig_sel,
  input  logic                       left_adj,
  input  logic                       irq_clr,
  input  logic [CHW-1:0]             chan_in,
  input  logic                       cmp_gt,
  output logic [CHW-1:0]             chan_mux,
  output logic                       sample_hold,
  output logic [NBITS-1:0]           dac_code,
  output logic                       busy,
  output logic [RES_W-1:0]           result,
  output logic                       irq_flag
);
  conv_mode_e       mode;
  logic             go;
  logic             done;
  logic [NBITS-1:0] code;

  assign mode = conv_mode_e'(mode_sel);

  sar_start_gen #(.NTRIG_LOG2(NTRIG_LOG2)) u_start (
    .clk(clk), .rst(rst), .mode(mode), .start_req(start_req),
    .trig_in(trig_in), .trig_sel(trig_sel), .idle(!busy), .go(go)
  );

  sar_bit_engine #(.NBITS(NBITS), .SAMPLE_CYC(SAMPLE_CYC), .CHW(CHW)) u_engine (
    .clk(clk), .rst(rst), .go(go), .free_run(mode == MODE_FREE),
    .chan_in(chan_in), .cmp_gt(cmp_gt), .busy(busy),
    .sample_hold(sample_hold), .dac_code(dac_code), .chan_mux(chan_mux),
    .done(done), .code(code)
  );

  sar_result_reg #(.NBITS(NBITS), .RES_W(RES_W)) u_result (
    .clk(clk), .rst(rst), .wr(done), .code(code), .left_adj(left_adj),
    .irq_clr(irq_clr), .result(result), .irq(irq_flag)
  );

  // R6: no start is accepted while a conversion is running
  p_no_restart_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !go);
endmodule

// File: tb/tb_sar_conv_ctrl.sv
module tb_sar_conv_ctrl;
  localparam int SC = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode_sel = 2'd0;
  logic        start_req = 1'b0;
  logic [3:0]  trig_in = 4'd0;
  logic [1:0]  trig_sel = 2'd0;
  logic        left_adj = 1'b0;
  logic        irq_clr = 1'b0;
  logic [2:0]  chan_in = 3'd0;
  logic        cmp_gt;
  logic [2:0]  chan_mux;
  logic        sample_hold;
  logic [9:0]  dac_code;
  logic        busy;
  logic [15:0] result;
  logic        irq_flag;

  logic [9:0]  vin = 10'd0;
  logic [9:0]  held = 10'd0;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  // ideal sample-and-hold plus comparator
  always @(posedge clk) if (sample_hold) held <= vin;
  assign cmp_gt = dac_code > held;

  sar_conv_ctrl #(.SAMPLE_CYC(SC)) dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .start_req(start_req),
    .trig_in(trig_in), .trig_sel(trig_sel), .left_adj(left_adj),
    .irq_clr(irq_clr), .chan_in(chan_in), .cmp_gt(cmp_gt),
    .chan_mux(chan_mux), .sample_hold(sample_hold), .dac_code(dac_code),
    .busy(busy), .result(result), .irq_flag(irq_flag)
  );

  // fields: [13:4] input code, [3] left align, [2:0] channel
  localparam logic [13:0] VEC [8] = '{
    {10'd0,    1'b0, 3'd0},
    {10'd1023, 1'b0, 3'd7},
    {10'd512,  1'b1, 3'd2},
    {10'd511,  1'b0, 3'd5},
    {10'd1,    1'b1, 3'd1},
    {10'h155,  1'b0, 3'd6},
    {10'h2AA,  1'b1, 3'd3},
    {10'd700,  1'b0, 3'd4}
  };

  function automatic logic [15:0] fmt(logic [9:0] v, logic l);
    return l ? {v, 6'b0} : {6'b0, v};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq_flag && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic clear_irq();
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [9:0] last_v;
    last_v = 10'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 irq", irq_flag, 0);
    check("R1 result", result, 0);
    check("R1 sample_hold", sample_hold, 0);
    check("R1 dac_code", dac_code, 0);
    repeat (20) @(negedge clk);
    check("R5 no start no busy", busy, 0);
    check("R5 no start no irq", irq_flag, 0);

    // table walk: single conversions
    for (int i = 0; i < 8; i++) begin
      logic [9:0] v;
      logic       l;
      logic [2:0] c;
      {v, l, c} = VEC[i];
      @(negedge clk);
      vin = v; left_adj = l; chan_in = c; mode_sel = 2'd0; start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      check("R12 busy rises", busy, 1);
      n = 0;
      while (!irq_flag && n < 200) begin
        @(negedge clk);
        n++;
        if (n == SC) begin
          check("R3 first trial code", dac_code, 10'h200);
          check("R4 hold after sampling", sample_hold, 0);
        end
        if (n == SC + 1) begin
          check("R13 channel latched", chan_mux, c);
          check("R11 result unchanged mid-conversion", result, fmt(last_v, l));
          chan_in = ~c;
          vin = ~v;
        end
      end
      check("R12 latency", n, SC + 10);
      check("R2 R10 result", result, fmt(v, l));
      check("R12 busy falls", busy, 0);
      check("R13 channel held to end", chan_mux, c);
      repeat (3) @(negedge clk);
      check("R9 flag sticky", irq_flag, 1);
      clear_irq();
      check("R9 flag cleared", irq_flag, 0);
      last_v = v;
    end

    // R10: realign stored result without a conversion
    @(negedge clk) left_adj = 1'b0;
    #1 check("R10 right aligned", result, {6'b0, last_v});
    @(negedge clk) left_adj = 1'b1;
    #1 check("R10 left aligned", result, {last_v, 6'b0});

    // R6: start during busy is ignored
    @(negedge clk);
    vin = 10'd300; left_adj = 1'b0; start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    n = 0;
    while (!irq_flag && n < 200) begin
      @(negedge clk);
      n++;
      if (n == 4) start_req = 1'b1;
      if (n == 5) start_req = 1'b0;
    end
    check("R6 latency not restarted", n, SC + 10);
    check("R6 result", result, 10'd300);
    clear_irq();
    repeat (30) @(negedge clk);
    check("R6 no queued conversion busy", busy, 0);
    check("R6 no queued conversion irq", irq_flag, 0);

    // R9: a completion beats a simultaneous clear
    @(negedge clk);
    vin = 10'd77; start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    repeat (SC + 9) @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
    check("R9 set wins over clear", irq_flag, 1);
    clear_irq();

    // R7: free-running
    @(negedge clk);
    mode_sel = 2'd1; vin = 10'd100; start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    wait_irq(n);
    check("R7 first result", result, 10'd100);
    check("R7 busy kept high", busy, 1);
    vin = 10'd900; irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
    check("R7 resampling", sample_hold, 1);
    wait_irq(n);
    check("R7 second latency", n, SC + 9);
    check("R7 second result", result, 10'd900);
    mode_sel = 2'd0;
    clear_irq();
    wait_irq(n);
    clear_irq();
    repeat (25) @(negedge clk);
    check("R7 stops after mode change", busy, 0);

    // R8: auto-trigger
    @(negedge clk);
    mode_sel = 2'd2; trig_sel = 2'd1; vin = 10'd222;
    trig_in = 4'b0001;
    repeat (20) @(negedge clk);
    check("R8 unselected line ignored", busy, 0);
    check("R8 unselected line no irq", irq_flag, 0);
    trig_in = 4'b0000;
    @(negedge clk) trig_in = 4'b0010;
    @(negedge clk);
    check("R8 edge starts", busy, 1);
    wait_irq(n);
    check("R8 result", result, 10'd222);
    clear_irq();
    repeat (25) @(negedge clk);
    check("R8 held level no retrigger", irq_flag, 0);
    check("R8 held level idle", busy, 0);
    trig_in = 4'b0000;
    mode_sel = 2'd0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule